// File: doc/BRIEF.md
# Unavailable State Detector

This block follows the availability of a framed transmission link from a stream of one-second verdicts. Once per second an upstream classifier presents a strobe together with two flags: the second was errored, and/or the second was severely errored. The detector keeps a flag that reports whether the link is currently unavailable. The same flag serves as the failed-state alarm. It also keeps two 16-bit performance counters, one for errored seconds and one for severely errored seconds.

Entry to and exit from the unavailable state both depend on run length. A run of ten severely errored seconds in a row takes the link down. A run of ten seconds in a row without a severe error brings it back. While the link is down, both performance counters are frozen. Each change of state raises a one-clock interrupt pulse. The counters saturate and can be cleared synchronously without disturbing the state.

Top module: `link_unavail_mon`

## Requirements
- R1: The unavailable flag rises on the clock edge that samples the tenth consecutive strobed second with the severe flag set, provided the link was available before that second.
- R2: The unavailable flag falls on the clock edge that samples the tenth consecutive strobed second with the severe flag clear, provided the link was unavailable before that second.
- R3: A strobed second that is evaluated while the link is unavailable leaves the errored-second count unchanged.
- R4: A strobed second that is evaluated while the link is unavailable leaves the severely-errored-second count unchanged.
- R5: While the link is available, a strobed second with the errored or severe flag set adds one to the errored-second count, and a severe second also adds one to the severely-errored-second count. A clean second adds to neither count.
- R6: A second of the opposite kind restarts a run from zero. A non-severe second during an entry run, or a severe second during an exit run, means ten further seconds are needed to change state.
- R7: `state_irq` is high for exactly one clock, in the same cycle that the unavailable flag changes value. It is low at all other times.
- R8: Each counter stops at 65535 and does not wrap.
- R9: `cnt_clear` zeroes both counters on the next edge. It takes priority over an increment in the same cycle and does not change the unavailable flag.
- R10: After reset the link is available, both counters are zero and `state_irq` is low.
- R11: The errored and severe flags have no effect in a cycle where `sec_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_strobe | input | 1 | One-cycle pulse marking a classified second |
| sec_errored | input | 1 | The second was errored |
| sec_severe | input | 1 | The second was severely errored |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| unavail | output | 1 | Link unavailable (failed-state alarm) |
| state_irq | output | 1 | One-clock pulse on each state change |
| es_count | output | 16 | Errored-second count |
| ses_count | output | 16 | Severely-errored-second count |

## Verification
The hardest situation to reach from the ports is counter saturation, because it needs 65535 counted seconds. The stimulus reaches it by strobing an errored but non-severe second on every clock for that many cycles. This keeps the link available throughout. Interrupted runs are also hard to reach: the stimulus sends nine seconds of one kind, then one second of the other kind, then nine more. This exposes any run counter that fails to restart.

// File: rtl/link_unavail_pkg.sv
package link_unavail_pkg;

    typedef struct packed {
        logic valid;
        logic errored;
        logic severe;
    } sec_class_t;

    typedef enum logic {
        LINK_UP   = 1'b0,
        LINK_DOWN = 1'b1
    } link_state_e;

    function automatic logic counts_as_errored(input sec_class_t s);
        return s.errored | s.severe;
    endfunction

endpackage

// File: rtl/unavail_run_fsm.sv
module unavail_run_fsm
    import link_unavail_pkg::*;
#(
    parameter int ENTRY_RUN = 10,
    parameter int EXIT_RUN  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  sec_class_t sec_in,
    output logic       down,
    output logic       change_pulse
);
    localparam int MAX_RUN = (ENTRY_RUN > EXIT_RUN) ? ENTRY_RUN : EXIT_RUN;
    localparam int RUN_W   = $clog2(MAX_RUN + 1);

    link_state_e      state;
    logic [RUN_W-1:0] entry_run;
    logic [RUN_W-1:0] exit_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= LINK_UP;
            entry_run    <= '0;
            exit_run     <= '0;
            change_pulse <= 1'b0;
        end else begin
            change_pulse <= 1'b0;
            if (sec_in.valid) begin
                if (state == LINK_UP) begin
                    exit_run <= '0;
                    if (sec_in.severe) begin
                        if (entry_run == RUN_W'(ENTRY_RUN - 1)) begin
                            state        <= LINK_DOWN;
                            change_pulse <= 1'b1;
                            entry_run    <= '0;
                        end else begin
                            entry_run <= entry_run + 1'b1;
                        end
                    end else begin
                        entry_run <= '0;
                    end
                end else begin
                    entry_run <= '0;
                    if (!sec_in.severe) begin
                        if (exit_run == RUN_W'(EXIT_RUN - 1)) begin
                            state        <= LINK_UP;
                            change_pulse <= 1'b1;
                            exit_run     <= '0;
                        end else begin
                            exit_run <= exit_run + 1'b1;
                        end
                    end else begin
                        exit_run <= '0;
                    end
                end
            end
        end
    end

    assign down = (state == LINK_DOWN);

    // R1: the state can only go down on a strobed severe second that ends a full run
    p_entry_on_severe_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(down) |-> $past(sec_in.valid && sec_in.severe && entry_run == RUN_W'(ENTRY_RUN - 1)));

    // R2: the state can only come back up on a strobed clean second that ends a full run
    p_exit_on_clean_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(down) |-> $past(sec_in.valid && !sec_in.severe && exit_run == RUN_W'(EXIT_RUN - 1)));

    // R7: the pulse marks each state change and nothing else
    p_pulse_matches_change_r7: assert property (@(posedge clk) disable iff (rst)
        change_pulse == (down != $past(down)));

endmodule

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    // R8: a full counter stays full until cleared
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (count == TOP && !clr) |=> count == TOP);

    // R9: clear wins over increment
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

endmodule

// File: rtl/link_unavail_mon.sv
module link_unavail_mon
    import link_unavail_pkg::*;
#(
    parameter int ENTRY_RUN = 10,
    parameter int EXIT_RUN  = 10,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_strobe,
    input  logic             sec_errored,
    input  logic             sec_severe,
    input  logic             cnt_clear,
    output logic             unavail,
    output logic             state_irq,
    output logic [CNT_W-1:0] es_count,
    output logic [CNT_W-1:0] ses_count
);
    localparam int N_CNT = 2;

    sec_class_t       sec;
    logic [N_CNT-1:0] inc;
    logic [CNT_W-1:0] cnt [N_CNT];

    assign sec = '{valid: sec_strobe, errored: sec_errored, severe: sec_severe};

    unavail_run_fsm #(
        .ENTRY_RUN (ENTRY_RUN),
        .EXIT_RUN  (EXIT_RUN)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sec_in       (sec),
        .down         (unavail),
        .change_pulse (state_irq)
    );

    // counters gated by the state before this second is applied
    assign inc[0] = sec.valid && !unavail && counts_as_errored(sec);
    assign inc[1] = sec.valid && !unavail && sec.severe;

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        sat_event_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (cnt_clear),
            .inc   (inc[i]),
            .count (cnt[i])
        );
    end

    assign es_count  = cnt[0];
    assign ses_count = cnt[1];

    // R3: errored-second count frozen while unavailable
    p_es_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (sec_strobe && unavail && !cnt_clear) |=> $stable(es_count));

    // R4: severely-errored-second count frozen while unavailable
    p_ses_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (sec_strobe && unavail && !cnt_clear) |=> $stable(ses_count));

    // R11: no strobe, no change to state or counters
    p_idle_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
        (!sec_strobe && !cnt_clear) |=> ($stable(unavail) && $stable(es_count) && $stable(ses_count)));

endmodule

// File: tb/link_unavail_mon_tb.sv
`timescale 1ns/1ps
module link_unavail_mon_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_strobe = 1'b0;
    logic        sec_errored = 1'b0;
    logic        sec_severe = 1'b0;
    logic        cnt_clear = 1'b0;
    logic        unavail;
    logic        state_irq;
    logic [15:0] es_count;
    logic [15:0] ses_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    link_unavail_mon u_dut (
        .clk(clk), .rst(rst), .sec_strobe(sec_strobe), .sec_errored(sec_errored),
        .sec_severe(sec_severe), .cnt_clear(cnt_clear), .unavail(unavail),
        .state_irq(state_irq), .es_count(es_count), .ses_count(ses_count)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 200000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // one strobed second; returns 1 ns after the sampling edge
    task automatic send_sec(input logic err, input logic sev);
        @(negedge clk);
        sec_strobe  = 1'b1;
        sec_errored = err;
        sec_severe  = sev;
        @(posedge clk);
        #1;
        sec_strobe  = 1'b0;
        sec_errored = 1'b0;
        sec_severe  = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        cnt_clear = 1'b1;
        @(posedge clk);
        #1;
        cnt_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 unavail", unavail, 0);
        check("R10 irq", state_irq, 0);
        check("R10 es", es_count, 0);
        check("R10 ses", ses_count, 0);
    endtask

    task automatic t_counting();
        clear_counts();
        for (int i = 0; i < 3; i++) send_sec(1'b1, 1'b0);
        check("R5 es after errored", es_count, 3);
        check("R5 ses after errored", ses_count, 0);
        for (int i = 0; i < 2; i++) send_sec(1'b0, 1'b1);
        check("R5 es after severe", es_count, 5);
        check("R5 ses after severe", ses_count, 2);
        send_sec(1'b0, 1'b0);
        check("R5 es after clean", es_count, 5);
        // flags without strobe
        @(negedge clk);
        sec_errored = 1'b1;
        sec_severe  = 1'b1;
        @(posedge clk);
        #1;
        sec_errored = 1'b0;
        sec_severe  = 1'b0;
        check("R11 es no strobe", es_count, 5);
        check("R11 ses no strobe", ses_count, 2);
        check("R11 unavail no strobe", unavail, 0);
    endtask

    task automatic t_broken_entry();
        clear_counts();
        for (int i = 0; i < 9; i++) send_sec(1'b1, 1'b1);
        send_sec(1'b1, 1'b0);
        for (int i = 0; i < 9; i++) send_sec(1'b1, 1'b1);
        check("R6 entry run restart", unavail, 0);
        check("R5 ses broken run", ses_count, 18);
        send_sec(1'b0, 1'b0);
    endtask

    task automatic t_entry();
        clear_counts();
        for (int i = 0; i < 9; i++) send_sec(1'b0, 1'b1);
        check("R1 before tenth", unavail, 0);
        send_sec(1'b0, 1'b1);
        check("R1 after tenth", unavail, 1);
        check("R7 irq on entry", state_irq, 1);
        check("R5 es counts tenth", es_count, 10);
        check("R5 ses counts tenth", ses_count, 10);
        idle_cycle();
        check("R7 irq one clock", state_irq, 0);
        for (int i = 0; i < 3; i++) send_sec(1'b1, 1'b0);
        send_sec(1'b1, 1'b1);
        send_sec(1'b0, 1'b1);
        check("R3 es frozen", es_count, 10);
        check("R4 ses frozen", ses_count, 10);
    endtask

    task automatic t_exit();
        for (int i = 0; i < 9; i++) send_sec(1'b0, 1'b0);
        send_sec(1'b0, 1'b1);
        for (int i = 0; i < 9; i++) send_sec(1'b1, 1'b0);
        check("R6 exit run restart", unavail, 1);
        check("R7 no irq mid run", state_irq, 0);
        send_sec(1'b0, 1'b0);
        check("R2 after tenth clean", unavail, 0);
        check("R7 irq on exit", state_irq, 1);
        check("R3 es not counting tenth", es_count, 10);
        idle_cycle();
        check("R7 irq drops", state_irq, 0);
        send_sec(1'b1, 1'b0);
        check("R5 es resumes", es_count, 11);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 10; i++) send_sec(1'b0, 1'b1);
        check("R1 down again", unavail, 1);
        @(negedge clk);
        cnt_clear   = 1'b1;
        sec_strobe  = 1'b1;
        sec_errored = 1'b1;
        @(posedge clk);
        #1;
        cnt_clear   = 1'b0;
        sec_strobe  = 1'b0;
        sec_errored = 1'b0;
        check("R9 es cleared", es_count, 0);
        check("R9 ses cleared", ses_count, 0);
        check("R9 state kept", unavail, 1);
        for (int i = 0; i < 10; i++) send_sec(1'b0, 1'b0);
        check("R2 back up", unavail, 0);
        // clear wins over a counted increment
        send_sec(1'b1, 1'b0);
        @(negedge clk);
        cnt_clear   = 1'b1;
        sec_strobe  = 1'b1;
        sec_severe  = 1'b1;
        @(posedge clk);
        #1;
        cnt_clear   = 1'b0;
        sec_strobe  = 1'b0;
        sec_severe  = 1'b0;
        check("R9 clear beats inc es", es_count, 0);
        check("R9 clear beats inc ses", ses_count, 0);
    endtask

    task automatic t_saturate();
        clear_counts();
        @(negedge clk);
        sec_strobe  = 1'b1;
        sec_errored = 1'b1;
        repeat (65535) @(posedge clk);
        #1;
        check("R8 es reaches max", es_count, 65535);
        repeat (3) @(posedge clk);
        #1;
        sec_strobe  = 1'b0;
        sec_errored = 1'b0;
        check("R8 es holds max", es_count, 65535);
        check("R8 ses untouched", ses_count, 0);
        check("R8 state up", unavail, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_counting();
        t_broken_entry();
        t_entry();
        t_exit();
        t_clear();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule